// File: doc/BRIEF.md
# Single-Cycle Integer Subset Processor Core

This block is a compact 32-bit processor that fetches, decodes and completes one instruction per clock. It runs a fixed integer subset: register add, subtract and signed set-less-than, immediate add, set-less-than, AND and OR, upper-half constant load, word and byte loads and stores, equal and not-equal conditional branches, absolute jump, jump-and-link and jump-through-register. Inside it there is a 32-entry register file, an instruction decoder, an ALU and a load/store lane unit.

The core has two memory ports. The instruction port presents the program counter and takes the instruction word back in the same cycle. The data port presents a word-aligned address, write data and four byte enables, and takes the read word back in the same cycle. Memory writes are committed at the clock edge that ends the instruction. A full 32-bit constant is built in two instructions: an upper-half load followed by an OR of the lower half.

Top module: `rsc_core`

## Requirements
- R1: There are 32 registers of 32 bits. Register 0 always reads as zero, and any write aimed at it is dropped.
- R2: R-format splits the word into op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. With op 0 and shamt 0, funct 32 writes rs+rt to rd, funct 34 writes rs−rt to rd, and funct 42 writes 1 to rd when rs < rt as signed numbers and 0 otherwise.
- R3: I-format splits the word into op[31:26], rs[25:21], rt[20:16] and imm[15:0], and the result goes to rt. Op 8 adds the sign-extended imm. Op 10 is a signed less-than test against the sign-extended imm. Op 12 ANDs with the zero-extended imm. Op 13 ORs with the zero-extended imm.
- R4: Op 15 writes imm into bits 31:16 of rt and clears bits 15:0.
- R5: Op 35 loads the aligned word at rs + sign-extended imm into rt. Op 43 writes rt to that word with all four byte enables set, and it writes no register.
- R6: Op 32 reads one byte and sign-extends it into rt. Op 40 writes the low byte of rt with one enable only, so the other three bytes keep their values. Lanes are big-endian: address bits [1:0] = 0 selects data bits 31:24 (enable bit 3), and 3 selects bits 7:0 (enable bit 0).
- R7: Op 4 branches when rs equals rt, and op 5 branches when they differ. A taken branch goes to PC+4+(sign-extended imm × 4). Otherwise the PC moves to PC+4.
- R8: Op 2 jumps, and op 3 jumps and writes PC+4 to register 31. The target is {PC+4 bits 31:28, instr[25:0], 2'b00}.
- R9: Op 0 with funct 8 and shamt 0 loads the PC from rs.
- R10: Any other opcode, funct or non-zero shamt in R-format is treated as a no-op. It writes no register and no memory, and the PC moves to PC+4.
- R11: Reset is synchronous and active-low. It sets the PC to 0 and clears every register. While reset is held, no data-memory write is issued.
- R12: Exactly one instruction completes per clock. After a non-control instruction the next fetch address is the previous one plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Fetch byte address (program counter) |
| imem_rdata | input | 32 | Instruction word for imem_addr, same cycle |
| dmem_addr | output | 32 | Word-aligned data address |
| dmem_wdata | output | 32 | Store data, already placed in its byte lane |
| dmem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| dmem_we | output | 1 | Data write strobe, committed at the clock edge |
| dmem_rdata | input | 32 | Data word for dmem_addr, same cycle |

## Verification
The fetch address changes at the rising edge that ends each instruction. A register result is written at that same edge and is first visible to the next instruction. A store reaches the bench's memory at the edge that ends the store. The bench changes reset only at falling edges and samples imem_addr, dmem_we and its memory model only at falling edges, so every check happens half a cycle after the edge that settles the value. Register contents are never read directly: each program stores its results to memory and then parks in a one-instruction loop, and the memory is checked after a fixed count of cycles that is longer than the program.

// File: rtl/rsc_pkg.sv
`timescale 1ns/1ps
// Shared widths, opcode values and control types for the subset core.
// Assumes fixed 32-bit instruction formats.
package rsc_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);
    localparam int NBYTE  = XLEN / 8;

    localparam logic [5:0] OP_REG  = 6'd0;
    localparam logic [5:0] OP_J    = 6'd2;
    localparam logic [5:0] OP_JAL  = 6'd3;
    localparam logic [5:0] OP_BEQ  = 6'd4;
    localparam logic [5:0] OP_BNE  = 6'd5;
    localparam logic [5:0] OP_ADDI = 6'd8;
    localparam logic [5:0] OP_SLTI = 6'd10;
    localparam logic [5:0] OP_ANDI = 6'd12;
    localparam logic [5:0] OP_ORI  = 6'd13;
    localparam logic [5:0] OP_LUI  = 6'd15;
    localparam logic [5:0] OP_LB   = 6'd32;
    localparam logic [5:0] OP_LW   = 6'd35;
    localparam logic [5:0] OP_SB   = 6'd40;
    localparam logic [5:0] OP_SW   = 6'd43;

    localparam logic [5:0] FN_JR  = 6'd8;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_SLT, ALU_AND, ALU_OR, ALU_PASSB} alu_op_e;
    typedef enum logic [1:0] {IMM_SEXT, IMM_ZEXT, IMM_UPPER} imm_kind_e;
    typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_sel_e;

    typedef struct packed {
        logic      rf_we;
        dst_sel_e  dst_sel;
        alu_op_e   alu_op;
        logic      use_imm;
        imm_kind_e imm_kind;
        logic      mem_rd;
        logic      mem_wr;
        logic      mem_byte;
        logic      br_eq;
        logic      br_ne;
        logic      jump;
        logic      jreg;
        logic      link;
    } ctrl_t;
endpackage

// File: rtl/rsc_regfile.sv
`timescale 1ns/1ps
// Register file with two read ports and one write port.
// Entry 0 is never written and always reads as zero. Reset clears all entries.
module rsc_regfile #(
    parameter int WIDTH = rsc_pkg::XLEN,
    parameter int DEPTH = rsc_pkg::NREG,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ra1,
    input  logic [AW-1:0]    ra2,
    output logic [WIDTH-1:0] rd1,
    output logic [WIDTH-1:0] rd2,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd
);
    logic [WIDTH-1:0] regs [DEPTH];

    // Clear on reset, otherwise write any entry other than 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    // Combinational reads; address 0 is forced to zero.
    always_comb begin
        rd1 = (ra1 == '0) ? '0 : regs[ra1];
        rd2 = (ra2 == '0) ? '0 : regs[ra2];
    end

    // R1
    r0_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra1 == '0) |-> (rd1 == '0));
endmodule

// File: rtl/rsc_decode.sv
`timescale 1ns/1ps
// Instruction decoder: maps opcode, funct and shamt to a control bundle.
// Assumes an unlisted encoding must write nothing, so all controls default to 0.
module rsc_decode
    import rsc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    input  logic [4:0] shamt,
    output ctrl_t      ctrl
);
    // Decode the opcode first, then funct for register-format words.
    always_comb begin
        ctrl = '0;
        case (op)
            OP_REG: if (shamt == '0) begin
                case (funct)
                    FN_ADD: begin ctrl.rf_we = 1'b1; ctrl.dst_sel = DST_RD; ctrl.alu_op = ALU_ADD; end
                    FN_SUB: begin ctrl.rf_we = 1'b1; ctrl.dst_sel = DST_RD; ctrl.alu_op = ALU_SUB; end
                    FN_SLT: begin ctrl.rf_we = 1'b1; ctrl.dst_sel = DST_RD; ctrl.alu_op = ALU_SLT; end
                    FN_JR:  ctrl.jreg = 1'b1;
                    default: ;
                endcase
            end
            OP_ADDI: begin ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_ADD; ctrl.imm_kind = IMM_SEXT; end
            OP_SLTI: begin ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_SLT; ctrl.imm_kind = IMM_SEXT; end
            OP_ANDI: begin ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_AND; ctrl.imm_kind = IMM_ZEXT; end
            OP_ORI:  begin ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_OR;  ctrl.imm_kind = IMM_ZEXT; end
            OP_LUI:  begin ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_PASSB; ctrl.imm_kind = IMM_UPPER; end
            OP_LW:   begin ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.mem_rd = 1'b1; end
            OP_LB:   begin ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.mem_rd = 1'b1; ctrl.mem_byte = 1'b1; end
            OP_SW:   begin ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1; end
            OP_SB:   begin ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1; ctrl.mem_byte = 1'b1; end
            OP_BEQ:  ctrl.br_eq = 1'b1;
            OP_BNE:  ctrl.br_ne = 1'b1;
            OP_J:    ctrl.jump = 1'b1;
            OP_JAL:  begin ctrl.jump = 1'b1; ctrl.link = 1'b1; ctrl.rf_we = 1'b1; ctrl.dst_sel = DST_LINK; end
            default: ;
        endcase
    end
endmodule

// File: rtl/rsc_alu.sv
`timescale 1ns/1ps
// Integer ALU: add, subtract, signed less-than, AND, OR and pass of operand B.
// Purely combinational; the clock and reset are used only by the checks.
module rsc_alu
    import rsc_pkg::*;
#(
    parameter int WIDTH = XLEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);
    // Select the result for the requested operation.
    always_comb begin
        case (op)
            ALU_SUB:   y = a - b;
            ALU_SLT:   y = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_PASSB: y = b;
            default:   y = a + b;
        endcase
    end

    // R2
    slt_is_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ALU_SLT) |-> (y[WIDTH-1:1] == '0));
endmodule

// File: rtl/rsc_lsu.sv
`timescale 1ns/1ps
// Load/store lane unit: aligns store data and byte enables, extracts and
// sign-extends loaded bytes. Lanes are big-endian (offset 0 = bits 31:24).
module rsc_lsu
    import rsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              mem_wr,
    input  logic              mem_byte,
    input  logic [XLEN-1:0]   eff_addr,
    input  logic [XLEN-1:0]   st_data,
    input  logic [XLEN-1:0]   rdata,
    output logic [XLEN-1:0]   dmem_addr,
    output logic [XLEN-1:0]   dmem_wdata,
    output logic [NBYTE-1:0]  dmem_be,
    output logic              dmem_we,
    output logic [XLEN-1:0]   ld_data
);
    logic [1:0] lane;
    logic [7:0] ld_byte;

    // Place store data and enables in the addressed lane.
    always_comb begin
        lane       = eff_addr[1:0];
        dmem_addr  = {eff_addr[XLEN-1:2], 2'b00};
        dmem_we    = en & mem_wr;
        dmem_wdata = mem_byte ? {NBYTE{st_data[7:0]}} : st_data;
        dmem_be    = mem_byte ? (4'b1000 >> lane) : {NBYTE{1'b1}};
    end

    // Pick the addressed byte of a load and sign-extend it.
    always_comb begin
        case (lane)
            2'd0:    ld_byte = rdata[31:24];
            2'd1:    ld_byte = rdata[23:16];
            2'd2:    ld_byte = rdata[15:8];
            default: ld_byte = rdata[7:0];
        endcase
        ld_data = mem_byte ? {{(XLEN-8){ld_byte[7]}}, ld_byte} : rdata;
    end

    // R6
    byte_store_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_we && mem_byte) |-> ($countones(dmem_be) == 1));
    // R5
    word_store_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_we && !mem_byte) |-> (dmem_be == 4'b1111));
endmodule

// File: rtl/rsc_core.sv
`timescale 1ns/1ps
// Single-cycle integer subset core. Each clock fetches, decodes and completes
// one instruction. Assumes both memories answer combinationally and that the
// data memory commits writes at the rising edge.
module rsc_core
    import rsc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [XLEN-1:0]   imem_addr,
    input  logic [XLEN-1:0]   imem_rdata,
    output logic [XLEN-1:0]   dmem_addr,
    output logic [XLEN-1:0]   dmem_wdata,
    output logic [NBYTE-1:0]  dmem_be,
    output logic              dmem_we,
    input  logic [XLEN-1:0]   dmem_rdata
);
    logic [XLEN-1:0]   pc, pc_plus4, next_pc, br_target;
    logic [XLEN-1:0]   rs_val, rt_val, imm_ext, imm_sext, alu_b, alu_y, ld_data, wd;
    logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, wa;
    logic [15:0]       imm;
    logic              taken;
    ctrl_t             ctrl;

    assign imem_addr = pc;
    assign rs_idx    = imem_rdata[25:21];
    assign rt_idx    = imem_rdata[20:16];
    assign rd_idx    = imem_rdata[15:11];
    assign imm       = imem_rdata[15:0];

    rsc_decode u_dec (
        .op(imem_rdata[31:26]), .funct(imem_rdata[5:0]), .shamt(imem_rdata[10:6]), .ctrl(ctrl)
    );

    rsc_regfile u_rf (
        .clk(clk), .rst_n(rst_n), .ra1(rs_idx), .ra2(rt_idx), .rd1(rs_val), .rd2(rt_val),
        .we(ctrl.rf_we), .wa(wa), .wd(wd)
    );

    // Extend the immediate as the instruction requires.
    always_comb begin
        imm_sext = {{16{imm[15]}}, imm};
        case (ctrl.imm_kind)
            IMM_ZEXT:  imm_ext = {16'h0, imm};
            IMM_UPPER: imm_ext = {imm, 16'h0};
            default:   imm_ext = imm_sext;
        endcase
        alu_b = ctrl.use_imm ? imm_ext : rt_val;
    end

    rsc_alu u_alu (.clk(clk), .rst_n(rst_n), .op(ctrl.alu_op), .a(rs_val), .b(alu_b), .y(alu_y));

    rsc_lsu u_lsu (
        .clk(clk), .rst_n(rst_n), .en(rst_n), .mem_wr(ctrl.mem_wr), .mem_byte(ctrl.mem_byte),
        .eff_addr(alu_y), .st_data(rt_val), .rdata(dmem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_be(dmem_be),
        .dmem_we(dmem_we), .ld_data(ld_data)
    );

    // Choose the destination register and its write value.
    always_comb begin
        case (ctrl.dst_sel)
            DST_RD:   wa = rd_idx;
            DST_LINK: wa = RIDX_W'(NREG - 1);
            default:  wa = rt_idx;
        endcase
        if (ctrl.link)        wd = pc_plus4;
        else if (ctrl.mem_rd) wd = ld_data;
        else                  wd = alu_y;
    end

    // Resolve the next fetch address: register jump, absolute jump, branch, sequential.
    always_comb begin
        pc_plus4  = pc + 32'd4;
        br_target = pc_plus4 + (imm_sext << 2);
        taken     = (ctrl.br_eq && rs_val == rt_val) || (ctrl.br_ne && rs_val != rt_val);
        if (ctrl.jreg)      next_pc = rs_val;
        else if (ctrl.jump) next_pc = {pc_plus4[31:28], imem_rdata[25:0], 2'b00};
        else if (taken)     next_pc = br_target;
        else                next_pc = pc_plus4;
    end

    // Program counter register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= RESET_PC;
        else        pc <= next_pc;
    end

    // R12
    seq_fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.jump && !ctrl.jreg && !ctrl.br_eq && !ctrl.br_ne) |=> (imem_addr == $past(imem_addr) + 32'd4));
    // R8
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.jump |=> (imem_addr[27:0] == {$past(imem_rdata[25:0]), 2'b00}));
endmodule

// File: tb/rsc_core_test.sv
`timescale 1ns/1ps
// Directed bench for the subset core: one task per scenario.
module rsc_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic [3:0]  dmem_be;
    logic        dmem_we;
    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    rsc_core uut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_be(dmem_be),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we)
            for (int i = 0; i < 4; i++)
                if (dmem_be[i]) dmem[dmem_addr[7:2]][8*i +: 8] <= dmem_wdata[8*i +: 8];
    end

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] tgt);
        return {op, tgt};
    endfunction
    localparam logic [31:0] PARK = 32'h1000FFFF; // branch-if-equal r0,r0 to itself

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin imem[i] = PARK; dmem[i] = 32'h0; end
    endtask

    task automatic reset_and_run(input int n);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // R2, R3: register and immediate arithmetic with signed compares.
    task automatic t_arith();
        clear_mem();
        imem[0]  = enc_i(6'd8, 0, 1, 16'd5);
        imem[1]  = enc_i(6'd8, 0, 2, 16'hFFFD);
        imem[2]  = enc_r(1, 2, 3, 6'd32);
        imem[3]  = enc_r(2, 1, 4, 6'd34);
        imem[4]  = enc_r(2, 1, 5, 6'd42);
        imem[5]  = enc_r(1, 2, 6, 6'd42);
        imem[6]  = enc_i(6'd10, 2, 7, 16'hFFFE);
        imem[7]  = enc_i(6'd43, 0, 3, 16'd0);
        imem[8]  = enc_i(6'd43, 0, 4, 16'd4);
        imem[9]  = enc_i(6'd43, 0, 5, 16'd8);
        imem[10] = enc_i(6'd43, 0, 6, 16'd12);
        imem[11] = enc_i(6'd43, 0, 7, 16'd16);
        reset_and_run(20);
        check("R2 add", dmem[0], 32'd2);
        check("R2 sub", dmem[1], 32'hFFFFFFF8);
        check("R2 slt true", dmem[2], 32'd1);
        check("R2 slt false", dmem[3], 32'd0);
        check("R3 slti signed", dmem[4], 32'd1);
    endtask

    // R11: reset holds PC at 0, blocks stores and clears registers.
    task automatic t_reset();
        clear_mem();
        dmem[0] = 32'hFFFFFFFF;
        dmem[1] = 32'hFFFFFFFF;
        imem[0] = enc_i(6'd40, 0, 0, 16'd0);
        imem[1] = enc_i(6'd43, 0, 1, 16'd4);
        @(negedge clk); rst_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R11 pc in reset", imem_addr, 32'h0);
            check("R11 no write in reset", {31'd0, dmem_we}, 32'd0);
        end
        check("R11 memory untouched", dmem[0], 32'hFFFFFFFF);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R6 byte store lane 0", dmem[0], 32'h00FFFFFF);
        check("R11 register cleared", dmem[1], 32'h0);
    endtask

    // R1, R3, R4: constants, extension kinds and register 0.
    task automatic t_const();
        clear_mem();
        dmem[9]  = 32'hDEADBEEF;
        imem[0]  = enc_i(6'd15, 0, 1, 16'hABCD);
        imem[1]  = enc_i(6'd13, 1, 1, 16'h8765);
        imem[2]  = enc_i(6'd12, 1, 2, 16'hFF0F);
        imem[3]  = enc_i(6'd13, 0, 3, 16'h8000);
        imem[4]  = enc_i(6'd8, 0, 4, 16'h8000);
        imem[5]  = enc_i(6'd8, 0, 0, 16'd7);
        imem[6]  = enc_i(6'd15, 0, 5, 16'h1234);
        imem[7]  = enc_i(6'd43, 0, 1, 16'd20);
        imem[8]  = enc_i(6'd43, 0, 2, 16'd24);
        imem[9]  = enc_i(6'd43, 0, 3, 16'd28);
        imem[10] = enc_i(6'd43, 0, 4, 16'd32);
        imem[11] = enc_i(6'd43, 0, 0, 16'd36);
        imem[12] = enc_i(6'd43, 0, 5, 16'd40);
        reset_and_run(20);
        check("R4 upper then or", dmem[5], 32'hABCD8765);
        check("R3 andi zero-extend", dmem[6], 32'h00008705);
        check("R3 ori zero-extend", dmem[7], 32'h00008000);
        check("R3 addi sign-extend", dmem[8], 32'hFFFF8000);
        check("R1 register 0 stays zero", dmem[9], 32'h0);
        check("R4 lower half cleared", dmem[10], 32'h12340000);
    endtask

    // R5, R6: word and byte loads and stores, lanes and negative offset.
    task automatic t_mem();
        clear_mem();
        dmem[12] = 32'h80FF7F01;
        dmem[14] = 32'hAAAAAAAA;
        dmem[15] = 32'h13572468;
        imem[0]  = enc_i(6'd8, 0, 8, 16'd48);
        imem[1]  = enc_i(6'd35, 8, 1, 16'd0);
        imem[2]  = enc_i(6'd43, 8, 1, 16'd4);
        imem[3]  = enc_i(6'd32, 8, 2, 16'd1);
        imem[4]  = enc_i(6'd32, 8, 3, 16'd2);
        imem[5]  = enc_i(6'd32, 8, 4, 16'd0);
        imem[6]  = enc_i(6'd40, 8, 3, 16'd11);
        imem[7]  = enc_i(6'd8, 0, 9, 16'd64);
        imem[8]  = enc_i(6'd35, 9, 5, 16'hFFFC);
        imem[9]  = enc_i(6'd43, 0, 2, 16'd0);
        imem[10] = enc_i(6'd43, 0, 4, 16'd4);
        imem[11] = enc_i(6'd43, 0, 5, 16'd8);
        imem[12] = enc_i(6'd43, 0, 3, 16'd12);
        reset_and_run(20);
        check("R5 word load and store", dmem[13], 32'h80FF7F01);
        check("R6 byte store lane 3 keeps others", dmem[14], 32'hAAAAAA7F);
        check("R6 byte load lane 1 negative", dmem[0], 32'hFFFFFFFF);
        check("R6 byte load lane 0 negative", dmem[1], 32'hFFFFFF80);
        check("R5 negative offset load", dmem[2], 32'h13572468);
        check("R6 byte load lane 2 positive", dmem[3], 32'h0000007F);
    endtask

    // R7, R8, R9: branches, jumps, link and return; PC traced every cycle.
    task automatic t_ctrl();
        logic [31:0] exp_pc [11] = '{32'd0, 32'd4, 32'd8, 32'd16, 32'd28, 32'd32,
                                     32'd20, 32'd24, 32'd40, 32'd44, 32'd44};
        clear_mem();
        imem[0]  = enc_i(6'd8, 0, 1, 16'd1);
        imem[1]  = enc_i(6'd4, 1, 0, 16'd2);
        imem[2]  = enc_i(6'd5, 1, 0, 16'd1);
        imem[3]  = enc_i(6'd8, 0, 2, 16'd99);
        imem[4]  = enc_j(6'd3, 26'd7);
        imem[5]  = enc_i(6'd43, 0, 31, 16'd60);
        imem[6]  = enc_j(6'd2, 26'd10);
        imem[7]  = enc_i(6'd8, 2, 2, 16'd5);
        imem[8]  = enc_r(31, 0, 0, 6'd8);
        imem[9]  = enc_i(6'd8, 0, 2, 16'd77);
        imem[10] = enc_i(6'd43, 0, 2, 16'd56);
        reset_and_run(0);
        for (int k = 0; k < 11; k++) begin
            check($sformatf("R7/R8/R9 fetch address step %0d", k), imem_addr, exp_pc[k]);
            @(negedge clk);
        end
        check("R8 link value", dmem[15], 32'd20);
        check("R7 skipped instruction", dmem[14], 32'd5);
    endtask

    // R10: unknown opcode, unknown funct and an unlisted store-like opcode do nothing.
    task automatic t_noop();
        clear_mem();
        dmem[2] = 32'h5A5A5A5A;
        imem[0] = enc_i(6'd8, 0, 1, 16'd9);
        imem[1] = enc_i(6'h3F, 0, 1, 16'd4);
        imem[2] = enc_r(0, 0, 1, 6'd63);
        imem[3] = enc_i(6'd41, 0, 1, 16'd8);
        imem[4] = enc_i(6'd43, 0, 1, 16'd0);
        reset_and_run(3);
        check("R10 pc steps over unknown", imem_addr, 32'd12);
        check("R10 no store strobe", {31'd0, dmem_we}, 32'd0);
        repeat (6) @(negedge clk);
        check("R10 register not written", dmem[0], 32'd9);
        check("R10 memory not written", dmem[2], 32'h5A5A5A5A);
    endtask

    initial begin
        t_arith();
        t_reset();
        t_const();
        t_mem();
        t_ctrl();
        t_noop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R12: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule